// File: doc/BRIEF.md
# Dual-Issue Interlock and Scoreboard

This block decides, cycle by cycle, what leaves the issue stage of an in-order pipeline that can start two instructions at once. Decode offers an older and a younger candidate. Each candidate carries an instruction class, up to three source register indices with a use mask, and an optional destination register. The block returns three outcomes. Both candidates start, or only the older one starts, or nothing starts and the older candidate is held. When only the older one starts, the decode side moves the younger candidate into the older slot for the next cycle.

A scoreboard keeps one down-counter per architectural register. When a producer issues, its destination counter is loaded with that producer's write-back latency. While the counter is non-zero, readers of that register are held, and so is any writer that would finish before it. The latency depends on the instruction class, and for floating-point instructions it also depends on the rounding-mode input at the moment of issue.

A taken-branch flush inserts three cycles with no issue. It also undoes the scoreboard writes made in the cycle just before it, which belong to the wrong path. Each affected counter goes back to the state its older producer would have reached. Counters of older instructions continue to count down untouched.

Top module: `dual_issue_ctl`

## Requirements
- R1: Two instructions start together only when one has class floating-point (code 2) and the other has class integer (code 0) or memory (code 1). Branch (code 3) and every other pairing start at most one instruction.
- R2: The younger candidate does not start alongside the older one when any of its used sources equals the older one's destination, or when both write the same destination.
- R3: `iss_y` is never high without `iss_o`. A pair that is refused still starts the older candidate when the older one is free of hazards.
- R4: After a producer issues in cycle t with latency L, a reader of its destination starts no earlier than cycle t+L+1. Integer and branch use L=1, and memory uses L=2.
- R5: A floating-point producer has L=3 when `rmode_i` is 0 at its issue, and L=4 when `rmode_i` is 1.
- R6: A candidate whose destination has an in-flight count greater than its own latency does not issue. A candidate whose latency is equal or larger may issue.
- R7: No instruction starts in the cycle `flush_i` is high or in the two cycles after it.
- R8: A flush returns each register that was written in the previous cycle to the count its earlier producer would have had. For example, two back-to-back L=4 writes to one register followed by a flush leave that register free three cycles after the flush.
- R9: After reset every register is free and there are no pending bubbles, so a valid older candidate starts in the first cycle.
- R10: `stall_o` is high exactly when the older candidate is valid and does not start.
- R11: A scoreboard hazard on a source or destination of the younger candidate blocks only the younger candidate.

Source slot k of a candidate occupies bits [6k+5:6k] of its source bus, and bit k of its use mask enables that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rmode_i | input | 1 | Rounding mode: 1 selects the longer floating-point latency |
| flush_i | input | 1 | Taken-branch flush |
| o_vld | input | 1 | Older candidate valid |
| o_cls | input | 2 | Older class: 0 integer, 1 memory, 2 floating-point, 3 branch |
| o_src | input | 18 | Older source indices, three 6-bit slots |
| o_suse | input | 3 | Older source use mask |
| o_dst | input | 6 | Older destination index |
| o_dwe | input | 1 | Older writes a destination |
| y_vld | input | 1 | Younger candidate valid |
| y_cls | input | 2 | Younger class |
| y_src | input | 18 | Younger source indices |
| y_suse | input | 3 | Younger source use mask |
| y_dst | input | 6 | Younger destination index |
| y_dwe | input | 1 | Younger writes a destination |
| iss_o | output | 1 | Older candidate starts this cycle |
| iss_y | output | 1 | Younger candidate starts this cycle |
| stall_o | output | 1 | Older candidate is held |

## Verification
The hardest situation to reach from the ports is a flush that lands right after a write-after-write overwrite of one register. The restored count only shows up if a reader tries that register on the exact cycle after the bubbles end. The directed stimulus sets this up deliberately: two long floating-point writes to one register on consecutive cycles, a flush on the next cycle, and then a reader held in place until it starts. A long random phase follows. It draws registers from a small pool so that intra-pair, scoreboard and flush interactions happen often, and it compares against a timestamp model every cycle.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MEM = 2'd1,
    CLS_FPU = 2'd2,
    CLS_BRA = 2'd3
  } iclass_e;

  // A pair is legal only as floating-point next to integer or memory.
  function automatic logic pairable(input iclass_e a, input iclass_e b);
    return ((a == CLS_FPU) && ((b == CLS_INT) || (b == CLS_MEM))) ||
           ((b == CLS_FPU) && ((a == CLS_INT) || (a == CLS_MEM)));
  endfunction

endpackage

// File: rtl/sb_entry.sv
module sb_entry #(
  parameter int CW   = 3,
  parameter int MAXL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic [CW-1:0] lat_i,
  input  logic          flush_i,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] shadow_q;  // count the older producer would have had
  logic          young_q;   // written in the previous cycle
  logic          restore;

  function automatic logic [CW-1:0] dec1(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  assign restore = flush_i && young_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      young_q  <= 1'b0;
    end else if (set_i) begin
      cnt_q    <= lat_i;
      shadow_q <= dec1(cnt_q);
      young_q  <= 1'b1;
    end else if (restore) begin
      cnt_q    <= dec1(shadow_q);
      young_q  <= 1'b0;
    end else begin
      cnt_q    <= dec1(cnt_q);
      young_q  <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q != '0);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAXL));

  p_restore_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/sb_array.sv
module sb_array #(
  parameter int NREG = 64,
  parameter int RW   = 6,
  parameter int CW   = 3,
  parameter int MAXL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wa_en,
  input  logic [RW-1:0]    wa_idx,
  input  logic [CW-1:0]    wa_lat,
  input  logic             wb_en,
  input  logic [RW-1:0]    wb_idx,
  input  logic [CW-1:0]    wb_lat,
  input  logic             flush_i,
  output logic [NREG*CW-1:0] cnt_o,
  output logic [NREG-1:0]  busy_o
);

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic          hit_a;
    logic          hit_b;
    logic [CW-1:0] lat;
    assign hit_a = wa_en && (wa_idx == RW'(r));
    assign hit_b = wb_en && (wb_idx == RW'(r));
    assign lat   = hit_a ? wa_lat : wb_lat;
    sb_entry #(.CW(CW), .MAXL(MAXL)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (hit_a || hit_b),
      .lat_i   (lat),
      .flush_i (flush_i),
      .cnt_o   (cnt_o[r*CW +: CW]),
      .busy_o  (busy_o[r])
    );
  end

  p_single_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));

  p_no_write_on_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !(wa_en || wb_en));

endmodule

// File: rtl/hazard_chk.sv
module hazard_chk #(
  parameter int NREG = 64,
  parameter int RW   = 6,
  parameter int CW   = 3,
  parameter int NSRC = 3
) (
  input  logic [NREG*CW-1:0] cnt_i,
  input  logic [NREG-1:0]    busy_i,
  input  logic [NSRC*RW-1:0] src_i,
  input  logic [NSRC-1:0]    suse_i,
  input  logic [RW-1:0]      dst_i,
  input  logic               dwe_i,
  input  logic [CW-1:0]      lat_i,
  output logic               raw_o,
  output logic               waw_o
);

  logic [NSRC-1:0] src_hit;
  logic [CW-1:0]   dst_cnt;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign src_hit[k] = suse_i[k] && busy_i[src_i[k*RW +: RW]];
  end

  assign raw_o   = |src_hit;
  assign dst_cnt = cnt_i[int'(dst_i)*CW +: CW];
  // A younger write must not finish before an in-flight one.
  assign waw_o   = dwe_i && (dst_cnt > lat_i);

endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dual_issue_pkg::*;
#(
  parameter int NREG     = 64,
  parameter int NSRC     = 3,
  parameter int LAT_INT  = 1,
  parameter int LAT_MEM  = 2,
  parameter int LAT_FP_N = 3,
  parameter int LAT_FP_X = 4,
  parameter int BUBBLES  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rmode_i,
  input  logic                         flush_i,
  input  logic                         o_vld,
  input  logic [1:0]                   o_cls,
  input  logic [NSRC*$clog2(NREG)-1:0] o_src,
  input  logic [NSRC-1:0]              o_suse,
  input  logic [$clog2(NREG)-1:0]      o_dst,
  input  logic                         o_dwe,
  input  logic                         y_vld,
  input  logic [1:0]                   y_cls,
  input  logic [NSRC*$clog2(NREG)-1:0] y_src,
  input  logic [NSRC-1:0]              y_suse,
  input  logic [$clog2(NREG)-1:0]      y_dst,
  input  logic                         y_dwe,
  output logic                         iss_o,
  output logic                         iss_y,
  output logic                         stall_o
);

  localparam int RW    = $clog2(NREG);
  localparam int MFP   = (LAT_FP_X > LAT_FP_N) ? LAT_FP_X : LAT_FP_N;
  localparam int MSIM  = (LAT_MEM > LAT_INT) ? LAT_MEM : LAT_INT;
  localparam int MAXL  = (MFP > MSIM) ? MFP : MSIM;
  localparam int CW    = $clog2(MAXL + 1);
  localparam int BW    = $clog2(BUBBLES + 1);

  function automatic logic [CW-1:0] lat_of(input logic [1:0] c, input logic rm);
    case (iclass_e'(c))
      CLS_MEM: return CW'(LAT_MEM);
      CLS_FPU: return rm ? CW'(LAT_FP_X) : CW'(LAT_FP_N);
      default: return CW'(LAT_INT);
    endcase
  endfunction

  // Named internal events
  logic [BW-1:0]      bub_q;
  logic               blocked;
  logic [CW-1:0]      lat_o, lat_y;
  logic               raw_o_s, waw_o_s, raw_y_s, waw_y_s;
  logic [NSRC-1:0]    pair_raw;
  logic               pair_waw;
  logic               pair_dep;
  logic               class_ok;
  logic               go_o, go_y;
  logic [NREG*CW-1:0] sb_cnt;
  logic [NREG-1:0]    sb_busy;

  // Branch bubbles
  always_ff @(posedge clk) begin
    if (!rst_n)            bub_q <= '0;
    else if (flush_i)      bub_q <= BW'(BUBBLES - 1);
    else if (bub_q != '0)  bub_q <= bub_q - BW'(1);
  end
  assign blocked = flush_i || (bub_q != '0);

  assign lat_o = lat_of(o_cls, rmode_i);
  assign lat_y = lat_of(y_cls, rmode_i);

  hazard_chk #(.NREG(NREG), .RW(RW), .CW(CW), .NSRC(NSRC)) u_hz_old (
    .cnt_i(sb_cnt), .busy_i(sb_busy), .src_i(o_src), .suse_i(o_suse),
    .dst_i(o_dst), .dwe_i(o_dwe), .lat_i(lat_o), .raw_o(raw_o_s), .waw_o(waw_o_s)
  );

  hazard_chk #(.NREG(NREG), .RW(RW), .CW(CW), .NSRC(NSRC)) u_hz_yng (
    .cnt_i(sb_cnt), .busy_i(sb_busy), .src_i(y_src), .suse_i(y_suse),
    .dst_i(y_dst), .dwe_i(y_dwe), .lat_i(lat_y), .raw_o(raw_y_s), .waw_o(waw_y_s)
  );

  // Dependencies inside the pair
  for (genvar k = 0; k < NSRC; k++) begin : g_pair
    assign pair_raw[k] = y_suse[k] && o_dwe && (y_src[k*RW +: RW] == o_dst);
  end
  assign pair_waw = o_dwe && y_dwe && (o_dst == y_dst);
  assign pair_dep = (|pair_raw) || pair_waw;
  assign class_ok = pairable(iclass_e'(o_cls), iclass_e'(y_cls));

  assign go_o = o_vld && !blocked && !raw_o_s && !waw_o_s;
  assign go_y = go_o && y_vld && class_ok && !pair_dep && !raw_y_s && !waw_y_s;

  assign iss_o   = go_o;
  assign iss_y   = go_y;
  assign stall_o = o_vld && !go_o;

  sb_array #(.NREG(NREG), .RW(RW), .CW(CW), .MAXL(MAXL)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (go_o && o_dwe),
    .wa_idx  (o_dst),
    .wa_lat  (lat_o),
    .wb_en   (go_y && y_dwe),
    .wb_idx  (y_dst),
    .wb_lat  (lat_y),
    .flush_i (flush_i),
    .cnt_o   (sb_cnt),
    .busy_o  (sb_busy)
  );

  // Assertions
  p_young_needs_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_y |-> iss_o);

  p_pair_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iss_y |-> ((o_cls == 2'd2 && y_cls inside {2'd0, 2'd1}) ||
               (y_cls == 2'd2 && o_cls inside {2'd0, 2'd1})));

  p_pair_waw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_y && o_dwe && y_dwe) |-> (o_dst != y_dst));

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    p_pair_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_y && o_dwe && y_suse[k]) |-> (y_src[k*RW +: RW] != o_dst));
    p_no_raw_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_o && o_suse[k]) |-> !sb_busy[o_src[k*RW +: RW]]);
  end

  p_sb_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && o_dwe) |=> sb_busy[$past(o_dst)]);

  p_waw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_o && o_dwe) |-> (sb_cnt[int'(o_dst)*CW +: CW] <= lat_o));

  p_flush_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !iss_o);

  p_bubble_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_i) && $past(rst_n)) |-> !iss_o);

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (o_vld && !iss_o));

endmodule

// File: tb/dual_issue_ctl_bench.sv
`timescale 1ns/1ps
module dual_issue_ctl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       rmode, flush, ov, od_we, yv, yd_we;
  logic [1:0] oc, yc;
  logic [5:0] os [3];
  logic [5:0] ys [3];
  logic [2:0] ou, yu;
  logic [5:0] od, yd;
  logic       iss_o, iss_y, stall;

  dual_issue_ctl u_dual_issue_ctl (
    .clk(clk), .rst_n(rst_n), .rmode_i(rmode), .flush_i(flush),
    .o_vld(ov), .o_cls(oc), .o_src({os[2], os[1], os[0]}), .o_suse(ou),
    .o_dst(od), .o_dwe(od_we),
    .y_vld(yv), .y_cls(yc), .y_src({ys[2], ys[1], ys[0]}), .y_suse(yu),
    .y_dst(yd), .y_dwe(yd_we),
    .iss_o(iss_o), .iss_y(iss_y), .stall_o(stall)
  );

  // Reference model: the cycle at which each register becomes readable.
  int avail [64];
  int saved [64];
  int last_iss [64];
  int last_flush, cyc, n_chk, n_fail;

  function automatic int rlat(input logic [1:0] c, input logic rm);
    if (c == 2'd1) return 2;
    if (c == 2'd2) return rm ? 4 : 3;
    return 1;
  endfunction

  function automatic bit slot_haz(input logic [5:0] s [3], input logic [2:0] u,
                                  input logic [5:0] d, input logic w, input int l);
    bit h = 0;
    for (int k = 0; k < 3; k++) if (u[k] && avail[s[k]] > cyc) h = 1;
    if (w && (avail[d] - cyc) > l) h = 1;
    return h;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic tick(input string tag);
    bit blk, ho, hy, intra, pok, eo, ey, es, fl;
    int lo, ly;
    #1;
    fl    = flush;
    blk   = fl || (cyc - last_flush <= 2);
    lo    = rlat(oc, rmode);
    ly    = rlat(yc, rmode);
    ho    = slot_haz(os, ou, od, od_we, lo);
    hy    = slot_haz(ys, yu, yd, yd_we, ly);
    intra = od_we && yd_we && (od == yd);
    for (int k = 0; k < 3; k++) if (yu[k] && od_we && ys[k] == od) intra = 1;
    pok   = (oc == 2'd2 && (yc == 2'd0 || yc == 2'd1)) ||
            (yc == 2'd2 && (oc == 2'd0 || oc == 2'd1));
    eo    = ov && !blk && !ho;
    ey    = eo && yv && pok && !intra && !hy;
    es    = ov && !eo;
    chk(tag, "iss_o", iss_o, eo);
    chk(tag, "iss_y", iss_y, ey);
    chk(tag, "stall", stall, es);
    @(posedge clk);
    if (fl) begin
      for (int r = 0; r < 64; r++) if (last_iss[r] == cyc - 1) avail[r] = saved[r];
      last_flush = cyc;
    end
    if (eo && od_we) begin
      saved[od] = avail[od]; avail[od] = cyc + lo + 1; last_iss[od] = cyc;
    end
    if (ey && yd_we) begin
      saved[yd] = avail[yd]; avail[yd] = cyc + ly + 1; last_iss[yd] = cyc;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic o_set(input int c, input int a, input int b, input int e,
                       input int u, input int d, input int w);
    ov = 1'b1; oc = c[1:0]; os[0] = a[5:0]; os[1] = b[5:0]; os[2] = e[5:0];
    ou = u[2:0]; od = d[5:0]; od_we = w[0];
  endtask

  task automatic y_set(input int c, input int a, input int b, input int e,
                       input int u, input int d, input int w);
    yv = 1'b1; yc = c[1:0]; ys[0] = a[5:0]; ys[1] = b[5:0]; ys[2] = e[5:0];
    yu = u[2:0]; yd = d[5:0]; yd_we = w[0];
  endtask

  task automatic idle();
    ov = 1'b0; yv = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    rmode = 0; flush = 0; idle();
    oc = 0; yc = 0; ou = 0; yu = 0; od = 0; yd = 0; od_we = 0; yd_we = 0;
    for (int k = 0; k < 3; k++) begin os[k] = 0; ys[k] = 0; end
    n_chk = 0; n_fail = 0; cyc = 0; last_flush = -100;
    for (int r = 0; r < 64; r++) begin avail[r] = 0; saved[r] = 0; last_iss[r] = -100; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    idle(); tick("R9");
    o_set(0, 1, 2, 3, 7, 4, 1); tick("R9");
    // R4, R10: integer producer then reader
    o_set(0, 4, 0, 0, 1, 5, 1); tick("R4 R10"); tick("R4");
    // R4: memory latency
    o_set(1, 0, 0, 0, 0, 12, 1); tick("R4");
    o_set(0, 12, 0, 0, 1, 13, 1); repeat (3) tick("R4");
    // R5: floating-point latency by rounding mode
    rmode = 0; o_set(2, 0, 0, 0, 0, 10, 1); tick("R5");
    o_set(0, 10, 0, 0, 1, 14, 1); repeat (4) tick("R5");
    rmode = 1; o_set(2, 0, 0, 0, 0, 11, 1); tick("R5");
    o_set(0, 11, 0, 0, 1, 15, 1); repeat (5) tick("R5");
    rmode = 0;
    // R1: pairing classes
    o_set(0, 1, 2, 0, 3, 20, 1); y_set(2, 3, 6, 0, 3, 21, 1); tick("R1");
    o_set(0, 1, 0, 0, 1, 22, 1); y_set(0, 2, 0, 0, 1, 23, 1); tick("R1 R3");
    o_set(2, 1, 0, 0, 1, 24, 1); y_set(2, 2, 0, 0, 1, 25, 1); tick("R1 R3");
    o_set(3, 1, 0, 0, 1, 26, 1); y_set(2, 2, 0, 0, 1, 27, 1); tick("R1");
    o_set(2, 1, 0, 0, 1, 28, 1); y_set(1, 2, 0, 0, 1, 29, 1); tick("R1");
    idle(); tick("R1");
    // R2, R3: intra-pair dependencies
    o_set(0, 1, 0, 0, 1, 40, 1); y_set(2, 6, 40, 0, 2, 41, 1); tick("R2 R3");
    o_set(0, 1, 0, 0, 1, 42, 1); y_set(2, 2, 0, 0, 1, 42, 1); tick("R2");
    // R11: younger reads a busy register
    o_set(0, 1, 0, 0, 1, 43, 1); y_set(2, 42, 0, 0, 1, 44, 1); tick("R11 R10");
    idle(); tick("R11");
    // R6: write-after-write against a longer in-flight producer
    rmode = 1; o_set(2, 0, 0, 0, 0, 50, 1); tick("R6");
    o_set(0, 0, 0, 0, 0, 50, 1); repeat (4) tick("R6");
    // R7: flush bubbles
    idle(); tick("R7");
    o_set(0, 1, 0, 0, 1, 51, 1); flush = 1; tick("R7");
    flush = 0; repeat (3) tick("R7");
    // R8: flush restores an overwritten entry
    o_set(2, 0, 0, 0, 0, 52, 1); tick("R8");
    o_set(2, 0, 0, 0, 0, 52, 1); tick("R8 R6");
    idle(); flush = 1; tick("R8");
    flush = 0; o_set(0, 52, 0, 0, 1, 54, 1); repeat (3) tick("R8");
    idle(); repeat (5) tick("R8");

    // Random phase over a small register pool
    for (int i = 0; i < 4000; i++) begin
      ov = ($urandom_range(0, 9) != 0);
      yv = ($urandom_range(0, 9) != 0);
      oc = 2'($urandom_range(0, 3)); yc = 2'($urandom_range(0, 3));
      for (int k = 0; k < 3; k++) begin
        os[k] = 6'($urandom_range(0, 7)); ys[k] = 6'($urandom_range(0, 7));
      end
      ou = 3'($urandom_range(0, 7)); yu = 3'($urandom_range(0, 7));
      od = 6'($urandom_range(0, 7)); yd = 6'($urandom_range(0, 7));
      od_we = ($urandom_range(0, 9) < 7); yd_we = ($urandom_range(0, 9) < 7);
      rmode = 1'($urandom_range(0, 1));
      flush = ($urandom_range(0, 24) == 0);
      tick("RND");
    end
    flush = 0; idle(); tick("RND");

    summary();
    $finish;
  end

endmodule